// File: doc/BRIEF.md
# Dual Interval Timer

This peripheral holds two 32-bit up-counters, each with its own count, limit and control register, reached over a plain synchronous register bus. Each bus cycle carries an address, a write enable and write data. Read data is combinational from the address. Each timer climbs one step per enabled clock. When it reaches its limit it goes back to zero, and if its interrupt enable is set it latches an interrupt that stays raised until software writes that timer's control register.

Software arms an interval by writing the limit, then zero to the count, then the control value. A limit of all ones turns a timer into a free-running counter that wraps from its top value to zero. A control bit ties counting to the processor halt input, so a timer can freeze while a debugger holds the core.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every count, limit and control register reads 0 and both interrupt outputs are low. With a limit of 0 the count stays at 0.
- R2: Registers sit at byte address 16*t + offset for timer t. The count is at offset 0x0, the control at 0x4 and the limit at 0x8. A read returns the addressed value in the same cycle. Any other address reads 0, and writes to it change nothing.
- R3: Control bit 0 is the interrupt enable and control bit 1 is the halt-gating enable. Control bits 31..2 are not stored and always read 0.
- R4: On each enabled clock the count goes up by one. If the count equals the limit on that clock, it becomes 0 instead, which gives a period of limit+1 enabled clocks.
- R5: A limit match sets the timer's interrupt only while its interrupt enable is 1. Once set, the interrupt stays high across later cycles and later matches.
- R6: Any write to a timer's control register, whatever its data, drives that timer's interrupt low from the next cycle.
- R7: When a control write and a limit match fall on the same clock, the clear wins and the interrupt stays low. The newly written enable then governs the following match.
- R8: With the halt-gating bit at 1 and the halt input high, the count holds its value. With the bit at 0, the timer counts whatever the halt input is.
- R9: A count write loads the written value on the next clock, in place of that clock's increment. That clock produces no limit match.
- R10: With the limit at 0xFFFFFFFF the count passes 0xFFFFFFFE, then 0xFFFFFFFF, then 0, then 1.
- R11: Writes to one timer leave the other timer's registers and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuHalted | input | 1 | High while the processor is halted |
| busAddr | input | 5 | Register byte address |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irq | output | 2 | Interrupt per timer, bit t for timer t |

## Verification
The properties assume that bus inputs change only between clock edges and that a write lasts exactly one cycle. They also assume that a timer's count changes only through its own increment or through a count write at that timer's count address. The bench drives every input on the falling edge, holds each write strobe for one cycle, and reads only with the write strobe low. The same-cycle ack-versus-match case relies on exact edge counting from a known count write, so each scenario re-arms its timer with a limit, count and control sequence before it counts edges.

// File: rtl/ditimer_pkg.sv
package ditimer_pkg;
  typedef struct packed {
    logic wrCount;
    logic wrCtrl;
    logic wrLimit;
  } timerStrobe_t;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_CTRL  = 2'd1,
    REG_LIMIT = 2'd2
  } regSel_e;

  localparam int CTRL_IE_BIT = 0;
  localparam int CTRL_NH_BIT = 1;
  localparam int CTRL_W      = 2;
  localparam int SLOT_BYTES  = 16;
endpackage

// File: rtl/ditimer_ctrl.sv
module ditimer_ctrl
  import ditimer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5
) (
  input  logic [ADDR_W-1:0]                     busAddr,
  input  logic                                  busWrEn,
  input  logic [NUM_TIMERS-1:0][DATA_W-1:0]     cntVal,
  input  logic [NUM_TIMERS-1:0][DATA_W-1:0]     limVal,
  input  logic [NUM_TIMERS-1:0][CTRL_W-1:0]     ctlVal,
  output timerStrobe_t [NUM_TIMERS-1:0]         strobes,
  output logic [DATA_W-1:0]                     busRdData
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] timerIdx;
  regSel_e          regSel;
  logic             idxOk;
  logic             regHit;

  assign timerIdx = busAddr[ADDR_W-1:4];
  assign regSel   = regSel_e'(busAddr[3:2]);
  assign idxOk    = ({1'b0, timerIdx} < (IDX_W+1)'(NUM_TIMERS));
  assign regHit   = idxOk && (busAddr[1:0] == 2'b00) && (busAddr[3:2] != 2'b11);

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_dec
    logic sel;
    assign sel = busWrEn && regHit && (timerIdx == IDX_W'(t));
    assign strobes[t].wrCount = sel && (regSel == REG_COUNT);
    assign strobes[t].wrCtrl  = sel && (regSel == REG_CTRL);
    assign strobes[t].wrLimit = sel && (regSel == REG_LIMIT);
  end

  always_comb begin
    busRdData = '0;
    if (regHit) begin
      case (regSel)
        REG_COUNT: busRdData = cntVal[timerIdx];
        REG_LIMIT: busRdData = limVal[timerIdx];
        REG_CTRL:  busRdData[CTRL_W-1:0] = ctlVal[timerIdx];
        default:   busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/ditimer_core.sv
module ditimer_core
  import ditimer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  cpuHalted,
  input  logic [DATA_W-1:0]                     busWrData,
  input  timerStrobe_t [NUM_TIMERS-1:0]         strobes,
  output logic [NUM_TIMERS-1:0][DATA_W-1:0]     cntVal,
  output logic [NUM_TIMERS-1:0][DATA_W-1:0]     limVal,
  output logic [NUM_TIMERS-1:0][CTRL_W-1:0]     ctlVal,
  output logic [NUM_TIMERS-1:0]                 irq
);
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic [DATA_W-1:0] countQ;
    logic [DATA_W-1:0] limitQ;
    logic [CTRL_W-1:0] ctrlQ;
    logic              pendQ;
    logic              runEn;
    logic              atLimit;
    logic              matchEvt;

    assign runEn    = !(ctrlQ[CTRL_NH_BIT] && cpuHalted);
    assign atLimit  = (countQ == limitQ);
    assign matchEvt = runEn && atLimit && !strobes[t].wrCount;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        countQ <= '0;
        limitQ <= '0;
        ctrlQ  <= '0;
        pendQ  <= 1'b0;
      end else begin
        if (strobes[t].wrCount)  countQ <= busWrData;
        else if (matchEvt)       countQ <= '0;
        else if (runEn)          countQ <= countQ + 1'b1;

        if (strobes[t].wrLimit)  limitQ <= busWrData;
        if (strobes[t].wrCtrl)   ctrlQ  <= busWrData[CTRL_W-1:0];

        if (strobes[t].wrCtrl)   pendQ  <= 1'b0;
        else if (matchEvt && ctrlQ[CTRL_IE_BIT]) pendQ <= 1'b1;
      end
    end

    assign cntVal[t] = countQ;
    assign limVal[t] = limitQ;
    assign ctlVal[t] = ctrlQ;
    assign irq[t]    = pendQ;
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import ditimer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4 + $clog2(NUM_TIMERS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuHalted,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  output logic [NUM_TIMERS-1:0] irq
);
  timerStrobe_t [NUM_TIMERS-1:0]     strobes;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] cntVal;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] limVal;
  logic [NUM_TIMERS-1:0][CTRL_W-1:0] ctlVal;

  ditimer_ctrl #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .cntVal    (cntVal),
    .limVal    (limVal),
    .ctlVal    (ctlVal),
    .strobes   (strobes),
    .busRdData (busRdData)
  );

  ditimer_core #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W)) i_core (
    .clk       (clk),
    .rstN      (rstN),
    .cpuHalted (cpuHalted),
    .busWrData (busWrData),
    .strobes   (strobes),
    .cntVal    (cntVal),
    .limVal    (limVal),
    .ctlVal    (ctlVal),
    .irq       (irq)
  );
endmodule

// File: rtl/ditimer_chk.sv
module ditimer_chk
  import ditimer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              cpuHalted,
  input logic [ADDR_W-1:0]                 busAddr,
  input logic                              busWrEn,
  input logic [DATA_W-1:0]                 busRdData,
  input logic [NUM_TIMERS-1:0]             irq,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0] cntVal,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0] limVal,
  input logic [NUM_TIMERS-1:0][CTRL_W-1:0] ctlVal
);
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chk
    localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(SLOT_BYTES*t);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(SLOT_BYTES*t + 4);
    logic wrCnt;
    logic wrCtl;
    logic running;
    assign wrCnt   = busWrEn && (busAddr == CNT_ADDR);
    assign wrCtl   = busWrEn && (busAddr == CTL_ADDR);
    assign running = !(ctlVal[t][CTRL_NH_BIT] && cpuHalted);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrCtl |=> !irq[t]);
    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irq[t] && !wrCtl) |=> irq[t]);
    // R5
    no_irq_without_ie_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!irq[t] && !ctlVal[t][CTRL_IE_BIT]) |=> !irq[t]);
    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctlVal[t][CTRL_NH_BIT] && cpuHalted && !wrCnt) |=> $stable(cntVal[t]));
    // R4
    limit_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (running && !wrCnt && cntVal[t] == limVal[t]) |=> (cntVal[t] == '0));
    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
      (running && !wrCnt && cntVal[t] != limVal[t]) |=> (cntVal[t] == $past(cntVal[t]) + 1'b1));
    // R3
    ctrl_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busAddr == CTL_ADDR) |-> (busRdData[DATA_W-1:CTRL_W] == '0));
  end
endmodule

bind dual_interval_timer ditimer_chk #(
  .NUM_TIMERS (NUM_TIMERS),
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuHalted (cpuHalted),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdData (busRdData),
  .irq       (irq),
  .cntVal    (cntVal),
  .limVal    (limVal),
  .ctlVal    (ctlVal)
);

// File: tb/test_dual_interval_timer.sv
`timescale 1ns/100ps
module test_dual_interval_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuHalted = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [4:0] T0_CNT = 5'h00, T0_CTL = 5'h04, T0_LIM = 5'h08;
  localparam logic [4:0] T1_CNT = 5'h10, T1_CTL = 5'h14, T1_LIM = 5'h18;

  dual_interval_timer i_dual_interval_timer (
    .clk(clk), .rstN(rstN), .cpuHalted(cpuHalted), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdData;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tReset();
    logic [31:0] v;
    foreach (checkAddrs[k]) begin
      rd(checkAddrs[k], v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 reset irq", {30'h0, irq}, 32'h0);
    waitEdges(3);
    rd(T0_CNT, v);
    check("R1 count idle at limit 0", v, 32'h0);
  endtask

  logic [4:0] checkAddrs [6] = '{T0_CNT, T0_CTL, T0_LIM, T1_CNT, T1_CTL, T1_LIM};

  task automatic tInterval();
    logic [31:0] v;
    wr(T0_LIM, 32'd5);
    wr(T0_CNT, 32'd0);
    wr(T0_CTL, 32'd1);
    rd(T0_CNT, v);
    check("R4 first step after arm", v, 32'd1);
    waitEdges(4);
    rd(T0_CNT, v);
    check("R4 count at limit", v, 32'd5);
    check("R5 no irq before match", {31'h0, irq[0]}, 32'd0);
    waitEdges(1);
    rd(T0_CNT, v);
    check("R4 wrap to zero", v, 32'd0);
    check("R5 irq on match", {31'h0, irq[0]}, 32'd1);
    waitEdges(9);
    check("R5 irq sticky", {31'h0, irq[0]}, 32'd1);
    check("R11 other irq untouched", {31'h0, irq[1]}, 32'd0);
  endtask

  task automatic tAck();
    logic [31:0] v;
    wr(T0_CTL, 32'hFFFF_FFFC);
    check("R6 ack with no-bit data", {31'h0, irq[0]}, 32'd0);
    rd(T0_CTL, v);
    check("R3 ctrl readback zero", v, 32'd0);
    waitEdges(14);
    check("R5 no irq with enable off", {31'h0, irq[0]}, 32'd0);
    wr(T0_CTL, 32'hFFFF_FFFF);
    rd(T0_CTL, v);
    check("R3 unused ctrl bits read 0", v, 32'h3);
    wr(T0_CTL, 32'h0000_0001);
  endtask

  task automatic tSameCycle();
    logic [31:0] v;
    wr(T0_LIM, 32'd3);
    wr(T0_CNT, 32'd0);
    wr(T0_CTL, 32'd1);
    waitEdges(2);
    rd(T0_CNT, v);
    check("R7 setup at limit", v, 32'd3);
    wr(T0_CTL, 32'd1);
    check("R7 clear wins over match", {31'h0, irq[0]}, 32'd0);
    rd(T0_CNT, v);
    check("R7 count wrapped", v, 32'd0);
    waitEdges(3);
    check("R7 no irq before next match", {31'h0, irq[0]}, 32'd0);
    waitEdges(1);
    check("R7 new enable applies next match", {31'h0, irq[0]}, 32'd1);
  endtask

  task automatic tHalt();
    logic [31:0] v;
    cpuHalted = 1'b1;
    wr(T1_CTL, 32'd2);
    wr(T1_LIM, 32'd100);
    wr(T1_CNT, 32'd10);
    rd(T1_CNT, v);
    check("R9 count load", v, 32'd10);
    waitEdges(5);
    rd(T1_CNT, v);
    check("R8 held while halted", v, 32'd10);
    cpuHalted = 1'b0;
    waitEdges(3);
    rd(T1_CNT, v);
    check("R8 runs when released", v, 32'd13);
    cpuHalted = 1'b1;
    wr(T1_CTL, 32'd0);
    rd(T1_CNT, v);
    check("R8 held on gate-off edge", v, 32'd13);
    waitEdges(4);
    rd(T1_CNT, v);
    check("R8 counts ungated while halted", v, 32'd17);
    cpuHalted = 1'b0;
    rd(T0_LIM, v);
    check("R11 timer0 limit kept", v, 32'd3);
    check("R11 timer0 irq kept", {31'h0, irq[0]}, 32'd1);
  endtask

  task automatic tFreeRun();
    logic [31:0] v;
    wr(T1_LIM, 32'hFFFF_FFFF);
    wr(T1_CNT, 32'hFFFF_FFFE);
    rd(T1_CNT, v);
    check("R10 load near top", v, 32'hFFFF_FFFE);
    waitEdges(1);
    rd(T1_CNT, v);
    check("R10 top value", v, 32'hFFFF_FFFF);
    waitEdges(1);
    rd(T1_CNT, v);
    check("R10 wrap to zero", v, 32'h0);
    waitEdges(1);
    rd(T1_CNT, v);
    check("R10 after wrap", v, 32'h1);
  endtask

  task automatic tUnmapped();
    logic [31:0] v;
    wr(5'h0C, 32'hAAAA_5555);
    wr(5'h1C, 32'h1234_5678);
    rd(5'h0C, v);
    check("R2 unmapped reads zero", v, 32'h0);
    rd(T0_LIM, v);
    check("R2 unmapped write ignored t0", v, 32'd3);
    rd(T1_LIM, v);
    check("R2 unmapped write ignored t1", v, 32'hFFFF_FFFF);
    wr(T1_LIM, 32'hCAFE_0001);
    rd(T1_LIM, v);
    check("R2 limit readback t1", v, 32'hCAFE_0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tInterval();
    tAck();
    tSameCycle();
    tHalt();
    tFreeRun();
    tUnmapped();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule